// File: doc/BRIEF.md
# Disk DMA Count and Address Register Block

This block holds the programming state of a disk DMA channel. The CPU sets a 16-bit count/control word that carries a transfer count, a direction flag and an enable. The CPU sets a 22-bit DMA word address in two halves. The address is not taken from the data bus. It is captured from the CPU address lines of the write cycle, and one address line selects which half is loaded. Bit 0 of the DMA address is always zero because transfers move whole 16-bit words.

A separate transfer engine uses the block through a single advance strobe. Each accepted advance moves the address on by one word and steps the count. When the count rolls over its top value, the channel disables itself and raises a done flag. When the CPU writes a count word whose direction bit is clear, the block pulses a strobe that tells the engine a dummy transfer is due. The CPU can read the count back, with the two upper bits always reading as one. Any access to the count register that is not 16 bits wide is reported on a size error output.

Top module: `dma_xfer_regs`

## Requirements
- R1: After reset, the count, enable, direction, done flag, DMA address, dummy strobe and size error are all zero.
- R2: A word-sized write (size code 2'b01) to the count register sets the count to (data[13:0] + 1) modulo 2^14, the direction to data[14] and the enable to data[15]. The write clears the done flag. The new values appear on the outputs in the cycle after the write.
- R3: The dummy strobe is high for exactly the one cycle that follows a word-sized count write with data[14] equal to 0. It is low in every other cycle.
- R4: The count readback always equals {2'b11, count[13:0]}.
- R5: A read or write of the count register with a size code other than 2'b01 (byte 2'b00, long 2'b10, reserved 2'b11) raises the size error output for one cycle, in the cycle after the access. Such a write leaves the count, direction and enable unchanged.
- R6: An address-register write with address line A14 high loads A13..A1 into DMA address bits 21..9 and keeps bits 8..0.
- R7: An address-register write with A14 low loads A8..A1 into DMA address bits 8..1 and keeps bits 21..9. The data bus is ignored for address writes, whatever the access size.
- R8: DMA address bit 0 is always 0.
- R9: An advance strobe while enable is high adds 2 to the DMA address (modulo 2^22) and 1 to the count. While enable is low, the advance strobe changes nothing.
- R10: An accepted advance when the count is 0x3FFF sets the count to 0, clears the enable and sets the done flag. The done flag stays set until the next word-sized count write.
- R11: When a CPU write to a register and an advance fall in the same cycle, the CPU write decides that register's next value. The other register still follows the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel_cnt | input | 1 | CPU cycle addresses the count/control register |
| cpu_sel_adr | input | 1 | CPU cycle addresses the DMA address register |
| cpu_wr | input | 1 | Write cycle qualifier |
| cpu_rd | input | 1 | Read cycle qualifier |
| cpu_size | input | 2 | Access size: 00 byte, 01 word, 10 long, 11 reserved |
| cpu_addr | input | 14 | CPU address lines A14..A1 |
| cpu_wdata | input | 16 | CPU write data |
| cnt_rdata | output | 16 | Count register readback |
| size_err | output | 1 | One-cycle flag for a count access of the wrong size |
| eng_adv | input | 1 | Transfer engine advance strobe |
| dma_en | output | 1 | Channel enable |
| dma_dir | output | 1 | Transfer direction bit as written |
| dma_addr | output | 22 | DMA byte address, bit 0 always zero |
| dma_cnt | output | 14 | Current transfer count |
| dma_done | output | 1 | Count rolled over; channel stopped |
| dummy_stb | output | 1 | Dummy transfer request pulse |

## Verification
The assertions assume that a CPU cycle never selects the count register and the address register at once. They also assume that a read and a write are never both asserted in the same cycle. The random stimulus draws a single operation per cycle, either a count access, an address write or neither, so these conditions always hold. The advance strobe is drawn independently, so it meets CPU writes often enough to exercise the priority rule. The count is preloaded near 0x3FFF so that rollover and stopping occur within a short run.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_WORD = 2'b01,
      SZ_LONG = 2'b10,
      SZ_RSV  = 2'b11
   } xfer_size_e;

   localparam int CTL_BITS = 2;   // direction + enable above the count
endpackage

// File: rtl/dma_size_gate.sv
module dma_size_gate
   import dma_regs_pkg::*;
#(
   parameter int REG_ERR = 1      // 1: registered error flag, 0: combinational
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       wr,
   input  logic       rd,
   input  logic [1:0] size,
   output logic       wr_ok,
   output logic       err
);
   logic size_word;
   logic bad_now;

   assign size_word = (xfer_size_e'(size) == SZ_WORD);
   assign wr_ok     = sel & wr & size_word;
   assign bad_now   = sel & (wr | rd) & ~size_word;

   generate
      if (REG_ERR != 0) begin : g_reg
         logic err_q;
         always_ff @(posedge clk) begin
            if (!rst_n) err_q <= 1'b0;
            else        err_q <= bad_now;
         end
         assign err = err_q;
      end else begin : g_comb
         assign err = bad_now;
      end
   endgenerate
endmodule

// File: rtl/dma_cnt_reg.sv
module dma_cnt_reg
   import dma_regs_pkg::*;
#(
   parameter int CNT_W = 14
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ld,
   input  logic [CNT_W+CTL_BITS-1:0] ld_data,
   input  logic                      adv,
   output logic [CNT_W-1:0]          cnt,
   output logic                      en,
   output logic                      dir,
   output logic                      done,
   output logic                      dummy,
   output logic [CNT_W+CTL_BITS-1:0] rdata
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic adv_ok;
   assign adv_ok = adv & en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt   <= '0;
         en    <= 1'b0;
         dir   <= 1'b0;
         done  <= 1'b0;
         dummy <= 1'b0;
      end else if (ld) begin
         cnt   <= ld_data[CNT_W-1:0] + CNT_ONE;
         dir   <= ld_data[CNT_W];
         en    <= ld_data[CNT_W+1];
         done  <= 1'b0;
         dummy <= ~ld_data[CNT_W];
      end else begin
         dummy <= 1'b0;
         if (adv_ok) begin
            cnt <= cnt + CNT_ONE;
            if (cnt == CNT_MAX) begin
               en   <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // readback: control positions always read as ones
   assign rdata = {{CTL_BITS{1'b1}}, cnt};
endmodule

// File: rtl/dma_adr_reg.sv
module dma_adr_reg #(
   parameter int ADR_W   = 22,
   parameter int LO_TOP  = 9,
   parameter int SEL_BIT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld,
   input  logic [SEL_BIT:1]  a,
   input  logic              adv,
   output logic [ADR_W-1:0]  addr
);
   localparam int HI_W = ADR_W - LO_TOP;
   localparam int LO_W = LO_TOP - 1;

   logic [HI_W-1:0] hi_q;
   logic [LO_W-1:0] lo_q;
   logic [ADR_W-2:0] word_nx;

   assign word_nx = {hi_q, lo_q} + (ADR_W-1)'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (ld) begin
         if (a[SEL_BIT]) hi_q <= a[HI_W:1];
         else            lo_q <= a[LO_W:1];
      end else if (adv) begin
         hi_q <= word_nx[ADR_W-2:LO_W];
         lo_q <= word_nx[LO_W-1:0];
      end
   end

   assign addr = {hi_q, lo_q, 1'b0};
endmodule

// File: rtl/dma_xfer_regs.sv
module dma_xfer_regs
   import dma_regs_pkg::*;
#(
   parameter int CNT_W   = 14,
   parameter int ADR_W   = 22,
   parameter int LO_TOP  = 9,
   parameter int SEL_BIT = 14,
   parameter int REG_ERR = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cpu_sel_cnt,
   input  logic                      cpu_sel_adr,
   input  logic                      cpu_wr,
   input  logic                      cpu_rd,
   input  logic [1:0]                cpu_size,
   input  logic [SEL_BIT:1]          cpu_addr,
   input  logic [CNT_W+CTL_BITS-1:0] cpu_wdata,
   output logic [CNT_W+CTL_BITS-1:0] cnt_rdata,
   output logic                      size_err,
   input  logic                      eng_adv,
   output logic                      dma_en,
   output logic                      dma_dir,
   output logic [ADR_W-1:0]          dma_addr,
   output logic [CNT_W-1:0]          dma_cnt,
   output logic                      dma_done,
   output logic                      dummy_stb
);
   localparam int HI_W = ADR_W - LO_TOP;

   generate
      if (HI_W > SEL_BIT - 1) begin : g_bad_hi
         $error("upper address half wider than available address lines");
      end
      if (LO_TOP < 2 || LO_TOP > SEL_BIT) begin : g_bad_lo
         $error("lower address half does not fit below the select line");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("count width too small");
      end
   endgenerate

   logic cnt_ld;
   logic adr_ld;

   dma_size_gate #(.REG_ERR(REG_ERR)) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (cpu_sel_cnt),
      .wr    (cpu_wr),
      .rd    (cpu_rd),
      .size  (cpu_size),
      .wr_ok (cnt_ld),
      .err   (size_err)
   );

   dma_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld      (cnt_ld),
      .ld_data (cpu_wdata),
      .adv     (eng_adv),
      .cnt     (dma_cnt),
      .en      (dma_en),
      .dir     (dma_dir),
      .done    (dma_done),
      .dummy   (dummy_stb),
      .rdata   (cnt_rdata)
   );

   assign adr_ld = cpu_sel_adr & cpu_wr;

   dma_adr_reg #(.ADR_W(ADR_W), .LO_TOP(LO_TOP), .SEL_BIT(SEL_BIT)) u_adr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (adr_ld),
      .a     (cpu_addr),
      .adv   (eng_adv & dma_en),
      .addr  (dma_addr)
   );
endmodule

// File: rtl/dma_regs_chk.sv
module dma_regs_chk
   import dma_regs_pkg::*;
#(
   parameter int CNT_W   = 14,
   parameter int ADR_W   = 22,
   parameter int LO_TOP  = 9,
   parameter int SEL_BIT = 14
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      cpu_sel_cnt,
   input logic                      cpu_sel_adr,
   input logic                      cpu_wr,
   input logic                      cpu_rd,
   input logic [1:0]                cpu_size,
   input logic [SEL_BIT:1]          cpu_addr,
   input logic [CNT_W+CTL_BITS-1:0] cpu_wdata,
   input logic [CNT_W+CTL_BITS-1:0] cnt_rdata,
   input logic                      size_err,
   input logic                      eng_adv,
   input logic                      dma_en,
   input logic                      dma_dir,
   input logic [ADR_W-1:0]          dma_addr,
   input logic [CNT_W-1:0]          dma_cnt,
   input logic                      dma_done,
   input logic                      dummy_stb
);
   localparam int HI_W = ADR_W - LO_TOP;
   localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

   logic cw, bad, aw;
   assign cw  = cpu_sel_cnt & cpu_wr & (cpu_size == 2'b01);
   assign bad = cpu_sel_cnt & (cpu_wr | cpu_rd) & (cpu_size != 2'b01);
   assign aw  = cpu_sel_adr & cpu_wr;

   assert_cnt_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cw |=> (dma_cnt == CNT_W'($past(cpu_wdata[CNT_W-1:0]) + 1'b1))
             && (dma_dir == $past(cpu_wdata[CNT_W])) && !dma_done);

   assert_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cw && !cpu_wdata[CNT_W]) |=> dummy_stb);

   assert_no_dummy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cw && !cpu_wdata[CNT_W]) |=> !dummy_stb);

   assert_readback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rdata[CNT_W+1:CNT_W] == 2'b11 && cnt_rdata[CNT_W-1:0] == dma_cnt);

   assert_size_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> size_err);

   assert_size_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bad && !eng_adv) |=> ($stable(dma_cnt) && $stable(dma_dir) && $stable(dma_en)));

   assert_hi_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (aw && cpu_addr[SEL_BIT]) |=>
         (dma_addr[ADR_W-1:LO_TOP] == $past(cpu_addr[HI_W:1]))
         && (dma_addr[LO_TOP-1:0] == $past(dma_addr[LO_TOP-1:0])));

   assert_lo_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (aw && !cpu_addr[SEL_BIT]) |=>
         (dma_addr[LO_TOP-1:1] == $past(cpu_addr[LO_TOP-1:1]))
         && (dma_addr[ADR_W-1:LO_TOP] == $past(dma_addr[ADR_W-1:LO_TOP])));

   assert_bit0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      dma_addr[0] == 1'b0);

   assert_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_adv && dma_en && !aw) |=> dma_addr == ADR_W'($past(dma_addr) + 2));

   assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_adv && !dma_en && !aw && !cw) |=> ($stable(dma_addr) && $stable(dma_cnt)));

   assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_adv && dma_en && dma_cnt == CMAX && !cw) |=>
         (!dma_en && dma_done && dma_cnt == '0));
endmodule

bind dma_xfer_regs dma_regs_chk #(
   .CNT_W(CNT_W), .ADR_W(ADR_W), .LO_TOP(LO_TOP), .SEL_BIT(SEL_BIT)
) u_chk (.*);

// File: tb/sim_dma_xfer_regs.sv
`timescale 1ns/1ps
module sim_dma_xfer_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_sel_cnt = 0, cpu_sel_adr = 0, cpu_wr = 0, cpu_rd = 0;
   logic [1:0]  cpu_size = 2'b01;
   logic [14:1] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic        eng_adv = 0;
   logic [15:0] cnt_rdata;
   logic        size_err, dma_en, dma_dir, dma_done, dummy_stb;
   logic [21:0] dma_addr;
   logic [13:0] dma_cnt;

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 0;

   // model state
   logic [13:0] m_cnt;
   logic        m_en, m_dir, m_done, m_err, m_dummy;
   logic [21:0] m_addr;

   always #2 clk = ~clk;

   dma_xfer_regs u0 (.*);

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic logic [21:0] ld_hi(logic [21:0] a, logic [14:1] ln);
      return {ln[13:1], a[8:0]};
   endfunction

   function automatic logic [21:0] ld_lo(logic [21:0] a, logic [14:1] ln);
      return {a[21:9], ln[8:1], 1'b0};
   endfunction

   task automatic model_reset();
      m_cnt = '0; m_en = 0; m_dir = 0; m_done = 0; m_err = 0; m_dummy = 0; m_addr = '0;
   endtask

   // one cycle: drive at negedge, update model, compare after edge
   task automatic cyc(input logic sc, input logic sa, input logic wr, input logic rd,
                      input logic [1:0] sz, input logic [14:1] a, input logic [15:0] wd,
                      input logic adv);
      logic cw, bad, aw, adv_ok;
      string tc, ta;
      @(negedge clk);
      cpu_sel_cnt = sc; cpu_sel_adr = sa; cpu_wr = wr; cpu_rd = rd;
      cpu_size = sz; cpu_addr = a; cpu_wdata = wd; eng_adv = adv;
      cw = sc & wr & (sz == 2'b01);
      bad = sc & (wr | rd) & (sz != 2'b01);
      aw = sa & wr;
      adv_ok = adv & m_en;
      m_err = bad;
      m_dummy = cw & ~wd[14];
      tc = cw ? (adv_ok ? "R11" : "R2") : (bad ? "R5" : (adv_ok ? "R9" : "R9"));
      if (cw) begin
         m_cnt = wd[13:0] + 14'd1; m_dir = wd[14]; m_en = wd[15]; m_done = 0;
      end else if (adv_ok) begin
         if (m_cnt == 14'h3FFF) begin m_en = 0; m_done = 1; tc = "R10"; end
         m_cnt = m_cnt + 14'd1;
      end
      ta = "R9";
      if (aw) begin
         ta = adv_ok ? "R11" : (a[14] ? "R6" : "R7");
         m_addr = a[14] ? ld_hi(m_addr, a) : ld_lo(m_addr, a);
      end else if (adv_ok) begin
         m_addr = (m_addr + 22'd2) & 22'h3FFFFE;
      end
      @(posedge clk);
      #1;
      chk({tc, " count"}, 32'(dma_cnt), 32'(m_cnt));
      chk({tc, " enable"}, 32'(dma_en), 32'(m_en));
      chk({tc, " dir"}, 32'(dma_dir), 32'(m_dir));
      chk({tc, " done"}, 32'(dma_done), 32'(m_done));
      chk({ta, " address"}, 32'(dma_addr), 32'(m_addr));
      chk("R8 addr bit0", 32'(dma_addr[0]), 32'd0);
      chk("R4 readback", 32'(cnt_rdata), {16'h0, 2'b11, m_cnt});
      chk("R5 size_err", 32'(size_err), 32'(m_err));
      chk("R3 dummy_stb", 32'(dummy_stb), 32'(m_dummy));
   endtask

   task automatic idle();
      cyc(0, 0, 0, 0, 2'b01, '0, '0, 0);
   endtask

   initial begin
      #(4 * 190000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20417));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      #0;
      chk("R1 count", 32'(dma_cnt), 0);
      chk("R1 enable", 32'(dma_en), 0);
      chk("R1 address", 32'(dma_addr), 0);
      chk("R1 done", 32'(dma_done), 0);
      chk("R1 strobes", {30'd0, dummy_stb, size_err}, 0);
      idle();

      // directed: R2 load with wrap on load, direction 1 -> no dummy
      cyc(1, 0, 1, 0, 2'b01, '0, 16'hFFFF, 0);   // count 0, en 1, dir 1
      cyc(1, 0, 1, 0, 2'b01, '0, 16'h8005, 0);   // dir 0 -> dummy (R3)
      idle();
      // R5: byte, long, reserved writes and a byte read
      cyc(1, 0, 1, 0, 2'b00, '0, 16'h1234, 0);
      cyc(1, 0, 1, 0, 2'b10, '0, 16'h4321, 0);
      cyc(1, 0, 1, 0, 2'b11, '0, 16'h0000, 0);
      cyc(1, 0, 0, 1, 2'b00, '0, 16'h0000, 0);
      cyc(1, 0, 0, 1, 2'b01, '0, 16'h0000, 0);
      // R6 / R7 address halves, data bus ignored
      cyc(0, 1, 1, 0, 2'b01, 14'h3FFF, 16'hFFFF, 0);
      cyc(0, 1, 1, 0, 2'b00, 14'h2155, 16'h0000, 0);
      cyc(0, 1, 1, 0, 2'b10, 14'h00AA, 16'hAAAA, 0);
      // R9 advances, R10 wrap
      cyc(1, 0, 1, 0, 2'b01, '0, 16'hBFFD, 0);   // count 3FFE, en
      cyc(0, 0, 0, 0, 2'b01, '0, '0, 1);
      cyc(0, 0, 0, 0, 2'b01, '0, '0, 1);          // wrap here
      cyc(0, 0, 0, 0, 2'b01, '0, '0, 1);          // ignored, en low
      idle();
      // address wrap at top of range
      cyc(0, 1, 1, 0, 2'b01, 14'h3FFF, '0, 0);
      cyc(0, 1, 1, 0, 2'b01, 14'h00FF, '0, 0);
      cyc(1, 0, 1, 0, 2'b01, '0, 16'hC100, 0);
      cyc(0, 0, 0, 0, 2'b01, '0, '0, 1);
      // R11 collisions
      cyc(1, 0, 1, 0, 2'b01, '0, 16'h9000, 1);
      cyc(0, 1, 1, 0, 2'b01, 14'h2001, '0, 1);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int op;
         logic [15:0] wd;
         logic [1:0] sz;
         op = $urandom_range(0, 9);
         wd = 16'($urandom);
         if ($urandom_range(0, 3) == 0) wd[13:0] = 14'h3FF0 | 14'($urandom_range(0, 15));
         if ($urandom_range(0, 2) != 0) wd[15] = 1'b1;
         sz = ($urandom_range(0, 4) == 0) ? 2'($urandom) : 2'b01;
         case (op)
            0:       cyc(1, 0, 1, 0, sz, '0, wd, 1'($urandom));
            1:       cyc(1, 0, 0, 1, sz, '0, wd, 1'($urandom));
            2, 3:    cyc(0, 1, 1, 0, sz, 14'($urandom), wd, 1'($urandom));
            default: cyc(0, 0, 0, 0, 2'b01, 14'($urandom), wd, $urandom_range(0, 3) != 0);
         endcase
      end

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule